// File: doc/BRIEF.md
# Flash Privilege Watermark Filter

This block splits a 256-Kbyte flash offset space into two parts with one programmable watermark. Offsets below the watermark form an unprivileged region that any access may use. Offsets at or above it are reserved for privileged accesses. The block sits between bus masters and the flash controller. It checks every flash access against the split and returns a grant. A refused read returns zero, a refused write never reaches the flash, and a one-cycle illegal-access pulse is raised.

The watermark is held in a single 32-bit register on a small register port. The register field counts 2-Kbyte pages, starting from offset 0. A field value at or above the full page count makes the whole space unprivileged. Whether the register accepts a write depends on the security and privilege attributes of the write, on a static flash-secure option and on a static configuration lock. A write that is refused raises a one-cycle rejection pulse. When the global security enable is low, the register can still be written and read, but every flash access is granted.

Top module: `flash_priv_wmark`

## Requirements
- R1: After reset the register reads 0x0FFF_0000, which is a page count of 0xFFF.
- R2: Only bits 27:16 (the page count) are stored. All other bits read as zero, and writes to them have no effect.
- R3: With security enabled, an unprivileged access at offset o is granted when floor(o / 2048) is less than the page count, and is denied otherwise.
- R4: A page count of 0 denies every unprivileged access. Any page count of 0x080 or more grants every offset up to 0x3FFFF.
- R5: A privileged access (acc_priv=1) is always granted.
- R6: When flash_secure=1, only writes with reg_sec=1 and reg_priv=1 update the register. When flash_secure=0, any write with reg_priv=1 updates it, whatever reg_sec is. Writes with reg_priv=0 never update it.
- R7: While cfg_lock=1, every register write is ignored.
- R8: A write to the register address that R6 or R7 refuses leaves the register unchanged. wr_reject is high for exactly the cycle after that write's clock edge.
- R9: When sec_en=0, every access is granted whatever the page count, and the register is still written and read as normal.
- R10: On a denied access, acc_rdata is zero and flash_we stays low. illegal_pulse is high in the cycle after the access's clock edge.
- R11: The decision uses the register value held before the current edge. An access issued in the same cycle as a register write is judged against the old page count.
- R12: Reads need no particular attributes. reg_rdata is registered: it shows the value for the address presented at the previous edge. Addresses other than WM_ADDR read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en | input | 1 | Global security enable (static) |
| flash_secure | input | 1 | Flash-secure option selecting the write rule (static) |
| cfg_lock | input | 1 | Configuration lock; blocks register writes |
| reg_addr | input | REG_AW | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_sec | input | 1 | Register transaction is secure |
| reg_priv | input | 1 | Register transaction is privileged |
| reg_rdata | output | 32 | Registered read data |
| wr_reject | output | 1 | One-cycle pulse for a refused register write |
| acc_valid | input | 1 | Flash access request |
| acc_write | input | 1 | Access is a write |
| acc_offset | input | 18 | Flash byte offset |
| acc_priv | input | 1 | Access is privileged |
| flash_rdata | input | 32 | Read data from the flash |
| acc_grant | output | 1 | Access permitted (combinational) |
| acc_rdata | output | 32 | Read data returned to the master, zero when denied |
| flash_we | output | 1 | Write strobe forwarded to the flash |
| illegal_pulse | output | 1 | One-cycle pulse after a denied access |

## Verification
On every cycle, the assertions check that privileged and security-disabled accesses are granted, that a zero page count denies unprivileged accesses, and that denied accesses never carry data or a write strobe. They also check that every denial is followed by the illegal pulse, that reserved bits read zero, and that locked or wrongly attributed writes leave the register unchanged. Only the directed scenarios can show the exact position of the watermark boundary and the saturation at 0x080. The same holds for the effect of flash_secure on which writes succeed, the old-value rule when a write and an access share a cycle, and the value read back after each kind of write.

// File: rtl/flash_wm_pkg.sv
package flash_wm_pkg;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = 12;
  localparam int LEN_LSB   = 16;
  localparam int FLASH_AW  = 18;
  localparam int GRAN_LOG2 = 11;
  localparam logic [LEN_W-1:0] LEN_RESET = 12'hFFF;
endpackage

// File: rtl/wm_cfg_reg.sv
module wm_cfg_reg
  import flash_wm_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter logic [REG_AW-1:0] WM_ADDR = 4'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_secure,
  input  logic              cfg_lock,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_sec,
  input  logic              reg_priv,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wr_reject
);
  logic [LEN_W-1:0]  len_q;
  logic              hit, attempt, attr_ok, wr_ok;
  logic [DATA_W-1:0] rd_word;

  assign hit     = (reg_addr == WM_ADDR);
  assign attempt = reg_we && hit;
  assign attr_ok = reg_priv && (reg_sec || !flash_secure);
  assign wr_ok   = attempt && attr_ok && !cfg_lock;

  always_comb begin
    rd_word = '0;
    rd_word[LEN_LSB +: LEN_W] = len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= LEN_RESET;
      reg_rdata <= '0;
      wr_reject <= 1'b0;
    end else begin
      if (wr_ok) len_q <= reg_wdata[LEN_LSB +: LEN_W];
      reg_rdata <= hit ? rd_word : '0;
      wr_reject <= attempt && !wr_ok;
    end
  end

  assign len_o = len_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> $stable(len_q)); // R7
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $stable(len_q)); // R8
  AST_FSEC_RULE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit && flash_secure && !reg_sec) |=> $stable(len_q)); // R6
  AST_UNPRIV_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_priv) |=> $stable(len_q)); // R6
endmodule

// File: rtl/wm_region_chk.sv
module wm_region_chk
  import flash_wm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sec_en,
  input  logic [LEN_W-1:0]    len,
  input  logic                acc_valid,
  input  logic [FLASH_AW-1:0] acc_offset,
  input  logic                acc_priv,
  output logic                grant
);
  localparam int PAGE_W = FLASH_AW - GRAN_LOG2;

  logic [PAGE_W-1:0] page;
  logic              in_low;

  assign page   = acc_offset[FLASH_AW-1:GRAN_LOG2];
  assign in_low = LEN_W'(page) < len;
  assign grant  = !sec_en || acc_priv || in_low;

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !sec_en) |-> grant); // R9
  AST_PRIV_GRANT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv) |-> grant); // R5
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sec_en && !acc_priv && len == '0) |-> !grant); // R4
endmodule

// File: rtl/flash_priv_wmark.sv
module flash_priv_wmark
  import flash_wm_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter logic [REG_AW-1:0] WM_ADDR = 4'h4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sec_en,
  input  logic                flash_secure,
  input  logic                cfg_lock,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_sec,
  input  logic                reg_priv,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                wr_reject,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [FLASH_AW-1:0] acc_offset,
  input  logic                acc_priv,
  input  logic [DATA_W-1:0]   flash_rdata,
  output logic                acc_grant,
  output logic [DATA_W-1:0]   acc_rdata,
  output logic                flash_we,
  output logic                illegal_pulse
);
  logic [LEN_W-1:0] len;

  wm_cfg_reg #(.REG_AW(REG_AW), .WM_ADDR(WM_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .flash_secure(flash_secure), .cfg_lock(cfg_lock),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_sec(reg_sec), .reg_priv(reg_priv), .len_o(len),
    .reg_rdata(reg_rdata), .wr_reject(wr_reject)
  );

  wm_region_chk u_chk (
    .clk(clk), .rst(rst), .sec_en(sec_en), .len(len),
    .acc_valid(acc_valid), .acc_offset(acc_offset), .acc_priv(acc_priv),
    .grant(acc_grant)
  );

  assign acc_rdata = (acc_valid && acc_grant && !acc_write) ? flash_rdata : '0;
  assign flash_we  = acc_valid && acc_write && acc_grant;

  always_ff @(posedge clk) begin
    if (rst) illegal_pulse <= 1'b0;
    else     illegal_pulse <= acc_valid && !acc_grant;
  end

  AST_DENY_PULSE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_grant) |=> illegal_pulse); // R10
  AST_DENY_DATA: assert property (@(posedge clk) disable iff (rst)
    !acc_grant |-> (acc_rdata == '0 && !flash_we)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:28] == 4'h0 && reg_rdata[15:0] == 16'h0)); // R2
endmodule

// File: tb/flash_priv_wmark_bench.sv
module flash_priv_wmark_bench;
  localparam logic [3:0] WA = 4'h4;
  localparam logic [31:0] FDATA = 32'hA5A5_5A5A;

  logic clk = 0, rst = 1;
  logic sec_en = 1, flash_secure = 1, cfg_lock = 0;
  logic [3:0] reg_addr = WA;
  logic reg_we = 0, reg_sec = 0, reg_priv = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic wr_reject;
  logic acc_valid = 0, acc_write = 0, acc_priv = 0;
  logic [17:0] acc_offset = 0;
  logic [31:0] flash_rdata = FDATA, acc_rdata;
  logic acc_grant, flash_we, illegal_pulse;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  flash_priv_wmark u_flash_priv_wmark (
    .clk(clk), .rst(rst), .sec_en(sec_en), .flash_secure(flash_secure),
    .cfg_lock(cfg_lock), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_sec(reg_sec), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .wr_reject(wr_reject), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_offset(acc_offset), .acc_priv(acc_priv),
    .flash_rdata(flash_rdata), .acc_grant(acc_grant), .acc_rdata(acc_rdata),
    .flash_we(flash_we), .illegal_pulse(illegal_pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d, logic s, logic p,
                          logic exp_rej, string req);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_sec = s; reg_priv = p; reg_we = 1;
    @(negedge clk);
    check(req, {31'b0, wr_reject}, {31'b0, exp_rej});
    reg_we = 0;
  endtask

  task automatic do_read(logic [3:0] a, logic s, logic p, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a; reg_sec = s; reg_priv = p;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  // expected grant for unprivileged access, computed from R3/R4/R9
  function automatic logic exp_grant(logic [17:0] off, logic [11:0] len, logic p, logic se);
    return !se || p || ({5'b0, off[17:11]} < len);
  endfunction

  task automatic do_access(logic [17:0] off, logic p, logic w, logic [11:0] len, string req);
    logic g;
    g = exp_grant(off, len, p, sec_en);
    @(negedge clk);
    acc_offset = off; acc_priv = p; acc_write = w; acc_valid = 1;
    #1;
    check(req, {31'b0, acc_grant}, {31'b0, g});
    check({req, "/R10 data"}, acc_rdata, (g && !w) ? FDATA : 32'h0);
    check({req, "/R10 we"}, {31'b0, flash_we}, {31'b0, g && w});
    @(negedge clk);
    check({req, "/R10 pulse"}, {31'b0, illegal_pulse}, {31'b0, !g});
    acc_valid = 0;
  endtask

  task automatic t_reset;
    do_read(WA, 0, 0, 32'h0FFF_0000, "R1 reset value");
    do_access(18'h3FFFF, 0, 0, 12'hFFF, "R4 reset full coverage");
  endtask

  task automatic t_reserved;
    do_write(WA, 32'hFFFF_FFFF, 1, 1, 0, "R2 write all ones");
    do_read(WA, 1, 1, 32'h0FFF_0000, "R2 reserved read zero");
    do_write(WA, 32'hF004_FFFF, 1, 1, 0, "R2 write len 4");
    do_read(WA, 0, 0, 32'h0004_0000, "R12 unpriv nonsecure read");
  endtask

  task automatic t_boundary;
    do_access(18'h01FFF, 0, 0, 12'h004, "R3 last unpriv byte");
    do_access(18'h02000, 0, 0, 12'h004, "R3 first priv byte read");
    do_access(18'h02000, 0, 1, 12'h004, "R3 priv region write dropped");
    do_access(18'h02000, 1, 1, 12'h004, "R5 privileged write");
    do_access(18'h3FFFF, 1, 0, 12'h004, "R5 privileged top");
  endtask

  task automatic t_extremes;
    do_write(WA, 32'h0000_0000, 1, 1, 0, "R4 write len 0");
    do_access(18'h00000, 0, 0, 12'h000, "R4 len 0 denies offset 0");
    do_write(WA, 32'h0080_0000, 1, 1, 0, "R4 write len 0x80");
    do_access(18'h3FFFF, 0, 1, 12'h080, "R4 saturated top");
    do_write(WA, 32'h007F_0000, 1, 1, 0, "R3 write len 0x7F");
    do_access(18'h3F7FF, 0, 0, 12'h07F, "R3 len 0x7F below");
    do_access(18'h3F800, 0, 0, 12'h07F, "R3 len 0x7F top page");
  endtask

  task automatic t_write_rules;
    flash_secure = 1;
    do_write(WA, 32'h0010_0000, 0, 1, 1, "R8 fsec nonsecure priv rejected");
    do_read(WA, 0, 1, 32'h007F_0000, "R6 unchanged");
    do_write(WA, 32'h0010_0000, 1, 0, 1, "R8 unpriv rejected");
    do_read(WA, 1, 0, 32'h007F_0000, "R6 unchanged unpriv");
    flash_secure = 0;
    do_write(WA, 32'h0010_0000, 0, 1, 0, "R6 nonsecure priv accepted");
    do_read(WA, 0, 0, 32'h0010_0000, "R6 value");
    do_write(WA, 32'h0020_0000, 0, 0, 1, "R6 unpriv rejected fsec=0");
    do_read(5'd0 + 4'h3, 1, 1, 32'h0, "R12 other address zero");
    flash_secure = 1;
  endtask

  task automatic t_lock;
    cfg_lock = 1;
    do_write(WA, 32'h0003_0000, 1, 1, 1, "R7 locked write rejected");
    do_read(WA, 1, 1, 32'h0010_0000, "R7 unchanged");
    cfg_lock = 0;
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_addr = WA; reg_wdata = 32'h0; reg_sec = 1; reg_priv = 1; reg_we = 1;
    acc_offset = 18'h00800; acc_priv = 0; acc_write = 0; acc_valid = 1;
    #1;
    check("R11 old value used", {31'b0, acc_grant}, 32'h1);
    @(negedge clk);
    reg_we = 0; acc_valid = 0;
    do_access(18'h00800, 0, 0, 12'h000, "R11 new value later");
  endtask

  task automatic t_sec_off;
    sec_en = 0;
    do_access(18'h3FFFF, 0, 0, 12'h000, "R9 transparent");
    do_write(WA, 32'h0002_0000, 1, 1, 0, "R9 write while off");
    do_read(WA, 0, 0, 32'h0002_0000, "R9 read while off");
    sec_en = 1;
    do_access(18'h01000, 0, 0, 12'h002, "R9 restored decision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_reserved();
    t_boundary();
    t_extremes();
    t_write_rules();
    t_lock();
    t_same_cycle();
    t_sec_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule